// File: doc/BRIEF.md
# Capture/Compare Timer Status Flags

This block keeps the event status flags for one channel of a multi-channel timer. There are two flags, B and C, and each is tied to its own capture/compare register. A flag rises in one of two ways, chosen per register by a mode input. In compare mode it rises when the free-running counter equals the register. In capture mode it rises when a capture strobe copies the counter into the register. The counter, the registers themselves and the capture datapath all sit outside the block. The block only sees their values and the strobes.

Software reads the flags through a simple read strobe and gets them back as registered read data. To clear a flag, software writes 0 to it. That write only takes effect if an earlier read returned the flag as 1. A transfer controller serving the flag's interrupt can also clear the flag when it acknowledges, as long as its disable-select input is 0. Each flag drives a level interrupt request, gated by a per-flag enable. A parameter sets whether the channel is a full channel, which has flag C, or a reduced channel, where flag C does not exist.

Top module: `tmr_flag_unit`

## Requirements
- R1: After synchronous reset, `flags`, `rd_data` and `irq` are all 0.
- R2: With a register in compare mode (its `cap_mode` bit = 0), the flag is 1 one clock after a cycle in which `cnt` equals that register's slice of `cmp_regs`.
- R3: With a register in capture mode (`cap_mode` bit = 1), a high `cap_stb` bit sets the flag one clock later. Equality of `cnt` with that register sets nothing in this mode.
- R4: A write (`wr_en`) with a 1 in a flag's data bit leaves that flag unchanged.
- R5: A write of 0 to a flag that has not been read as 1 since the last write leaves the flag at 1.
- R6: A read (`rd_en`) that sees a flag at 1 arms that flag. The next write of 0 then clears the flag one clock later. Any write consumes the arm, so a second write of 0 with no read in between does not clear.
- R7: `dma_ack` for a flag clears it one clock later when `dma_disel` = 0. When `dma_disel` = 1 it has no effect.
- R8: If a set condition and a clear (by software or by the controller) fall in the same cycle, the flag ends at 1.
- R9: `irq` bit i is registered. It equals flag i AND `irq_en` bit i, and it changes on the same clock edge as the flag.
- R10: With `FULL_CH` = 0, bit 1 (flag C) of `flags`, `rd_data` and `irq` always reads 0, whatever the strobes or writes.
- R11: A read updates `rd_data` one clock later with the flags as they stood in the read cycle. Without a read, `rd_data` holds. Bit 0 carries flag B and bit 1 carries flag C throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt | input | CNT_W | Free-running counter value |
| cmp_regs | input | 2*CNT_W | Register values: B in the low slice, C in the high slice |
| cap_mode | input | 2 | Per-register mode: 1 = capture, 0 = compare |
| cap_stb | input | 2 | Capture strobes |
| rd_en | input | 1 | Status read strobe |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 2 | Write data, one bit per flag |
| dma_ack | input | 2 | Transfer-controller activation per flag |
| dma_disel | input | 1 | Disable-select: 0 lets an activation clear the flag |
| irq_en | input | 2 | Interrupt enables |
| flags | output | 2 | Current flag state |
| rd_data | output | 2 | Registered read data |
| irq | output | 2 | Level interrupt requests |

## Verification
The set paths are driven in both modes. Counter equality is applied to a register in capture mode as well as in compare mode, so a design that ignores the mode select is caught. The clear paths are tried with a write of 1, with a write of 0 that follows no read, with a write of 0 that follows a consumed read, and with a properly armed write of 0. Each of these tells a correct read-then-write rule apart from a plain write-to-clear. Controller activations are applied with the disable-select at both values. Set and clear are also made to collide in the same cycle. A reduced-channel instance gets the same stimulus, which shows that flag C stays at 0 while flag B behaves the same as on the full channel.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;
  localparam int NUM_FLAGS = 2;
  localparam int IDX_B     = 0;
  localparam int IDX_C     = 1;

  typedef enum logic {
    MODE_COMPARE = 1'b0,
    MODE_CAPTURE = 1'b1
  } flag_mode_e;
endpackage

// File: rtl/tmr_flag_event.sv
module tmr_flag_event #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] reg_val,
  input  logic             mode,
  input  logic             cap_stb,
  output logic             set_o
);
  import tmr_flag_pkg::*;

  flag_mode_e mode_e;
  logic       hit_cmp;
  logic       hit_cap;

  always_comb begin
    mode_e  = flag_mode_e'(mode);
    hit_cmp = (mode_e == MODE_COMPARE) && (cnt == reg_val);
    hit_cap = (mode_e == MODE_CAPTURE) && cap_stb;
    set_o   = hit_cmp || hit_cap;
  end
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic rd_en,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic dma_ack,
  input  logic dma_disel,
  input  logic ien,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, arm_q, irq_q;
  logic sw_clr, dma_clr;
  logic flag_d, arm_d;

  always_comb begin
    sw_clr  = wr_en && !wr_bit && arm_q;
    dma_clr = dma_ack && !dma_disel;
    // set has priority so no event is lost
    if (set_i)                  flag_d = 1'b1;
    else if (sw_clr || dma_clr) flag_d = 1'b0;
    else                        flag_d = flag_q;
    if (rd_en && flag_q) arm_d = 1'b1;
    else if (wr_en)      arm_d = 1'b0;
    else                 arm_d = arm_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
      irq_q  <= flag_d && ien;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  // R2 R3 R8: any set event leaves the flag high
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q);

  // R6: armed write of zero clears
  p_sw_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_bit && arm_q && !set_i) |=> !flag_q);

  // R4 R5: without an armed zero write or controller clear, a set flag stays
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(wr_en && !wr_bit && arm_q) && !(dma_ack && !dma_disel)) |=> flag_q);

  // R7: controller activation with disable-select low clears
  p_dma_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (dma_ack && !dma_disel && !set_i) |=> !flag_q);

  // R9: request follows flag and enable
  p_irq_r9: assert property (@(posedge clk) disable iff (rst)
    ien |=> (irq_q == flag_q));
  p_irq_off_r9: assert property (@(posedge clk) disable iff (rst)
    !ien |=> !irq_q);
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit #(
  parameter int CNT_W   = 16,
  parameter bit FULL_CH = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CNT_W-1:0]     cnt,
  input  logic [2*CNT_W-1:0]   cmp_regs,
  input  logic [1:0]           cap_mode,
  input  logic [1:0]           cap_stb,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [1:0]           wr_data,
  input  logic [1:0]           dma_ack,
  input  logic                 dma_disel,
  input  logic [1:0]           irq_en,
  output logic [1:0]           flags,
  output logic [1:0]           rd_data
  , output logic [1:0]         irq
);
  import tmr_flag_pkg::*;

  localparam int NF = NUM_FLAGS;

  logic [NF-1:0] flag_w, irq_w;
  logic [NF-1:0] rd_q;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    if (i == IDX_C && !FULL_CH) begin : g_absent
      assign flag_w[i] = 1'b0;
      assign irq_w[i]  = 1'b0;
    end else begin : g_present
      logic set_w;
      tmr_flag_event #(.CNT_W(CNT_W)) u_evt (
        .cnt     (cnt),
        .reg_val (cmp_regs[i*CNT_W +: CNT_W]),
        .mode    (cap_mode[i]),
        .cap_stb (cap_stb[i]),
        .set_o   (set_w)
      );
      tmr_flag_cell u_cell (
        .clk       (clk),
        .rst       (rst),
        .set_i     (set_w),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .wr_bit    (wr_data[i]),
        .dma_ack   (dma_ack[i]),
        .dma_disel (dma_disel),
        .ien       (irq_en[i]),
        .flag_o    (flag_w[i]),
        .irq_o     (irq_w[i])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= flag_w;
  end

  assign flags   = flag_w;
  assign irq     = irq_w;
  assign rd_data = rd_q;

  // R11: read data is the snapshot from the read cycle
  p_rd_snap_r11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data == $past(flags)));
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/tb_tmr_flag_unit.sv
module tb_tmr_flag_unit;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst;
  logic [CW-1:0]   cnt;
  logic [2*CW-1:0] cmp_regs;
  logic [1:0] cap_mode, cap_stb, wr_data, dma_ack, irq_en;
  logic rd_en, wr_en, dma_disel;
  logic [1:0] flags_f, rd_f, irq_f, flags_r, rd_r, irq_r;

  always #4 clk = ~clk; // 125 MHz

  tmr_flag_unit #(.CNT_W(CW), .FULL_CH(1'b1)) dut (
    .clk(clk), .rst(rst), .cnt(cnt), .cmp_regs(cmp_regs), .cap_mode(cap_mode),
    .cap_stb(cap_stb), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .dma_ack(dma_ack), .dma_disel(dma_disel), .irq_en(irq_en),
    .flags(flags_f), .rd_data(rd_f), .irq(irq_f));

  tmr_flag_unit #(.CNT_W(CW), .FULL_CH(1'b0)) dut_r (
    .clk(clk), .rst(rst), .cnt(cnt), .cmp_regs(cmp_regs), .cap_mode(cap_mode),
    .cap_stb(cap_stb), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .dma_ack(dma_ack), .dma_disel(dma_disel), .irq_en(irq_en),
    .flags(flags_r), .rd_data(rd_r), .irq(irq_r));

  typedef struct {
    int         sel;
    logic [1:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [CW-1:0] RB = 16'h0010;
  localparam logic [CW-1:0] RC = 16'h0020;
  localparam logic [CW-1:0] IDLE_CNT = 16'h0100;

  task automatic expect_v(input int sel, input logic [1:0] v, input string req);
    item_t it;
    it.sel = sel; it.exp = v; it.req = req;
    q.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    cap_stb = 2'b00; rd_en = 1'b0; wr_en = 1'b0; wr_data = 2'b00;
    dma_ack = 2'b00; cnt = IDLE_CNT;
  endtask

  // monitor: compares queued items after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [1:0] act;
        string nm;
        it = q.pop_front();
        case (it.sel)
          0: begin act = flags_f; nm = "flags";    end
          1: begin act = rd_f;    nm = "rd_data";  end
          2: begin act = irq_f;   nm = "irq";      end
          3: begin act = flags_r; nm = "flags(r)"; end
          4: begin act = rd_r;    nm = "rd_data(r)"; end
          default: begin act = irq_r; nm = "irq(r)"; end
        endcase
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s %s actual=%b expected=%b", it.req, nm, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cap_mode = 2'b00; irq_en = 2'b00; dma_disel = 1'b1;
    cmp_regs = {RC, RB};
    idle();
    repeat (4) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    expect_v(0, 2'b00, "R1"); expect_v(1, 2'b00, "R1"); expect_v(2, 2'b00, "R1");
    expect_v(3, 2'b00, "R1"); expect_v(5, 2'b00, "R1");

    // R2 compare match on B
    cnt = RB; tick(); idle(); tick();
    expect_v(0, 2'b01, "R2"); expect_v(3, 2'b01, "R2");

    // R3 C in capture mode: equality alone does nothing, strobe sets
    cap_mode = 2'b10; cnt = RC; tick(); idle(); tick();
    expect_v(0, 2'b01, "R3");
    cap_stb = 2'b10; tick(); idle(); tick();
    expect_v(0, 2'b11, "R3");
    expect_v(3, 2'b01, "R10");

    // R5 zero write with no prior read
    wr_en = 1'b1; wr_data = 2'b00; tick(); idle(); tick();
    expect_v(0, 2'b11, "R5"); expect_v(3, 2'b01, "R5");

    // read arms; R4 write of ones changes nothing and consumes the arm
    rd_en = 1'b1; tick(); idle(); tick();
    expect_v(1, 2'b11, "R11"); expect_v(4, 2'b01, "R10");
    wr_en = 1'b1; wr_data = 2'b11; tick(); idle(); tick();
    expect_v(0, 2'b11, "R4"); expect_v(3, 2'b01, "R4");

    // R6 arm consumed: zero write does not clear
    wr_en = 1'b1; wr_data = 2'b00; tick(); idle(); tick();
    expect_v(0, 2'b11, "R6");
    // R6 read then zero write clears
    rd_en = 1'b1; tick(); idle();
    wr_en = 1'b1; wr_data = 2'b00; tick(); idle(); tick();
    expect_v(0, 2'b00, "R6"); expect_v(3, 2'b00, "R6");

    // R9 interrupt requests
    irq_en = 2'b11; cnt = RB; tick(); idle(); tick();
    expect_v(0, 2'b01, "R9"); expect_v(2, 2'b01, "R9"); expect_v(5, 2'b01, "R9");
    irq_en = 2'b00; tick(); tick();
    expect_v(2, 2'b00, "R9"); expect_v(0, 2'b01, "R9");

    // R7 controller activation
    dma_ack = 2'b01; dma_disel = 1'b1; tick(); idle(); tick();
    expect_v(0, 2'b01, "R7");
    dma_ack = 2'b01; dma_disel = 1'b0; tick(); idle(); tick();
    expect_v(0, 2'b00, "R7"); expect_v(3, 2'b00, "R7");

    // R8 set beats clear: B armed zero write with match, C capture with activation
    cnt = RB; tick(); idle();
    rd_en = 1'b1; tick(); idle();
    wr_en = 1'b1; wr_data = 2'b00; cnt = RB; cap_stb = 2'b10; dma_ack = 2'b10;
    tick(); idle(); tick();
    expect_v(0, 2'b11, "R8"); expect_v(3, 2'b01, "R8");

    // R11 snapshot then hold
    rd_en = 1'b1; tick(); idle(); tick();
    expect_v(1, 2'b11, "R11");
    dma_ack = 2'b11; tick(); idle(); tick();
    expect_v(0, 2'b00, "R7"); expect_v(1, 2'b11, "R11"); expect_v(4, 2'b01, "R11");
    expect_v(3, 2'b00, "R10"); expect_v(5, 2'b00, "R10");

    tick(); tick();
    #2;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule